// File: doc/BRIEF.md
# Serial Binary-to-BCD Converter

This block turns an unsigned binary word into packed decimal digits. A start strobe loads the word into a small parallel-to-serial front end and clears the digit register. The front end then feeds the converter one bit per clock, most significant bit first. With each bit, every decimal digit is doubled and the new bit enters the lowest digit.

The doubling is done one digit at a time. Digits 0 to 4 simply shift left. Digits 5 to 9 are remapped to 0, 2, 4, 6 and 8, and they send a carry into the digit above. As a result, every nibble holds a legal decimal value after every step. A three-state controller (idle, shifting, finished) sequences the work, and its size does not depend on the word width. The digit count is derived from the word width as the smallest count able to hold 2^N-1. The widths 4, 8, 16 and 24 bits are supported.

A converted value is presented with a done flag. Both hold until the next start.

Top module: `bcd_serial_conv`

## Requirements
- R1: When done_o is high, bcd_o equals the decimal value of the word loaded at start. Digit i (weight 10^i) sits at bits [4i+3:4i]. The digit count is the smallest D with 10^D > 2^N-1, so N=16 gives 5 digits and N=8 gives 3.
- R2: Every 4-bit nibble of bcd_o stays in the range 0 to 9 on every cycle.
- R3: Bits are consumed most significant first, one per rising edge. After the first shift edge, bcd_o equals the word's top bit (0 or 1).
- R4: A start_i sampled while not shifting clears all digits to zero on that edge and loads word_i into the serializer.
- R5: done_o rises on the N-th rising edge after the edge that samples start_i, and it stays low on the edges before that. The whole conversion spans N+1 edges, counting the start edge.
- R6: Once done_o is high, done_o and bcd_o hold unchanged until start_i is sampled. A start from the finished state begins a new conversion.
- R7: While shifting, start_i has no effect and changes on word_i are ignored. The result and its timing are those of the word loaded at start.
- R8: No carry leaves the top digit during a conversion.
- R9: While rst_ni is low, bcd_o is zero and done_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, honoured when not shifting |
| word_i | input | WIDTH_P | Unsigned binary word, sampled at start |
| bcd_o | output | 4*DIGITS | Packed BCD result, lowest digit in bits [3:0] |
| done_o | output | 1 | High while a finished result is held |

## Verification
The checker enforces four properties on every cycle: nibble legality, the absence of a carry out of the top digit, the clearing effect of an accepted start, and the hold of result and done once the conversion finishes. It also checks that the serializer's last-bit flag appears only while shifting.

Only the bench's scenarios can show three things: the decimal correctness of the result, the exact edge on which done rises, and the value seen after the first shifted bit. The same applies to R7, the immunity to start pulses and word changes in mid-conversion. To cover these, the bench sweeps every 8-bit word and a spread of 16-bit words, including the values at decimal digit boundaries.

// File: rtl/bcd_pkg.sv
package bcd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SHIFT  = 2'd1,
    ST_FINISH = 2'd2
  } conv_state_e;

  // smallest D with 10^D > 2^n - 1
  function automatic int digits_for(input int n);
    longint lim;
    longint p;
    int d;
    lim = longint'(1) << n;
    p = 1;
    d = 0;
    for (int i = 0; i < 20; i++) begin
      if (p < lim) begin
        p = p * 10;
        d = d + 1;
      end
    end
    return d;
  endfunction

endpackage

// File: rtl/bcd_serializer.sv
module bcd_serializer #(
  parameter int WIDTH_P = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               shift_i,
  input  logic [WIDTH_P-1:0] word_i,
  output logic               bit_o,
  output logic               last_o
);
  localparam int CNT_W = (WIDTH_P > 2) ? $clog2(WIDTH_P) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WIDTH_P - 1);

  logic [WIDTH_P-1:0] shreg_q;
  logic [CNT_W-1:0]   cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      cnt_q   <= '0;
    end else if (load_i) begin
      shreg_q <= word_i;
      cnt_q   <= '0;
    end else if (shift_i) begin
      shreg_q <= {shreg_q[WIDTH_P-2:0], 1'b0};
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign bit_o  = shreg_q[WIDTH_P-1];
  assign last_o = shift_i && (cnt_q == LAST_IDX);
endmodule

// File: rtl/bcd_digit.sv
module bcd_digit (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       shift_i,
  input  logic       carry_i,
  output logic [3:0] digit_o,
  output logic       carry_o
);
  logic [3:0] digit_q;
  logic [2:0] low3;

  // doubled-digit correction: 5..9 -> 0,2,4,6,8 with carry
  always_comb begin
    carry_o = 1'b1;
    unique case (digit_q)
      4'd5:    low3 = 3'd0;
      4'd6:    low3 = 3'd1;
      4'd7:    low3 = 3'd2;
      4'd8:    low3 = 3'd3;
      4'd9:    low3 = 3'd4;
      default: begin
        low3    = digit_q[2:0];
        carry_o = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      digit_q <= '0;
    else if (clear_i) digit_q <= '0;
    else if (shift_i) digit_q <= {low3, carry_i};
  end

  assign digit_o = digit_q;
endmodule

// File: rtl/bcd_ctrl.sv
module bcd_ctrl
  import bcd_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        last_i,
  output logic        load_o,
  output logic        shift_o,
  output logic        done_o,
  output conv_state_e state_o
);
  conv_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = ST_SHIFT;
      ST_SHIFT:  if (last_i)  state_d = ST_FINISH;
      ST_FINISH: if (start_i) state_d = ST_SHIFT;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign load_o  = start_i && (state_q != ST_SHIFT);
  assign shift_o = (state_q == ST_SHIFT);
  assign done_o  = (state_q == ST_FINISH);
  assign state_o = state_q;
endmodule

// File: rtl/bcd_serial_conv.sv
module bcd_serial_conv
  import bcd_pkg::*;
#(
  parameter  int WIDTH_P   = 16,
  localparam int DIGITS_LP = bcd_pkg::digits_for(WIDTH_P)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [WIDTH_P-1:0]     word_i,
  output logic [4*DIGITS_LP-1:0] bcd_o,
  output logic                   done_o
);
  logic        load, shift, ser_bit, ser_last;
  conv_state_e state;
  logic [DIGITS_LP:0] carry;
  logic        top_carry;

  bcd_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .last_i  (ser_last),
    .load_o  (load),
    .shift_o (shift),
    .done_o  (done_o),
    .state_o (state)
  );

  bcd_serializer #(.WIDTH_P(WIDTH_P)) u_ser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .shift_i (shift),
    .word_i  (word_i),
    .bit_o   (ser_bit),
    .last_o  (ser_last)
  );

  assign carry[0] = ser_bit;

  for (genvar g = 0; g < DIGITS_LP; g++) begin : g_digit
    bcd_digit u_digit (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (load),
      .shift_i (shift),
      .carry_i (carry[g]),
      .digit_o (bcd_o[4*g +: 4]),
      .carry_o (carry[g+1])
    );
  end

  assign top_carry = shift && carry[DIGITS_LP];
endmodule

// File: rtl/bcd_serial_conv_chk.sv
module bcd_serial_conv_chk
  import bcd_pkg::*;
#(
  parameter int WIDTH_P  = 16,
  parameter int DIGITS_P = 5
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  start_i,
  input logic                  done_o,
  input logic [4*DIGITS_P-1:0] bcd_o,
  input conv_state_e           state,
  input logic                  top_carry,
  input logic                  ser_last
);
  function automatic logic nibbles_ok(input logic [4*DIGITS_P-1:0] b);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < DIGITS_P; i++)
      if (b[4*i +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  a_r2_nibbles_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nibbles_ok(bcd_o));

  a_r8_no_top_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !top_carry);

  a_r4_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && state != ST_SHIFT) |=> (bcd_o == '0) && !done_o);

  a_r6_hold_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o && $stable(bcd_o));

  a_r7_last_only_shifting: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_last |-> state == ST_SHIFT);

  a_r9_reset_values: assert property (@(posedge clk_i)
    !rst_ni |-> (bcd_o == '0) && !done_o);
endmodule

bind bcd_serial_conv bcd_serial_conv_chk #(
  .WIDTH_P (WIDTH_P),
  .DIGITS_P(DIGITS_LP)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .done_o   (done_o),
  .bcd_o    (bcd_o),
  .state    (state),
  .top_carry(top_carry),
  .ser_last (ser_last)
);

// File: tb/bcd_serial_conv_tb.sv
module bcd_serial_conv_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        start8 = 1'b0, start16 = 1'b0;
  logic [7:0]  word8 = '0;
  logic [15:0] word16 = '0;
  logic [11:0] bcd8;
  logic [19:0] bcd16;
  logic        done8, done16;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  bcd_serial_conv #(.WIDTH_P(8)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start8), .word_i(word8),
    .bcd_o(bcd8), .done_o(done8)
  );

  bcd_serial_conv #(.WIDTH_P(16)) u_dut16 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start16), .word_i(word16),
    .bcd_o(bcd16), .done_o(done16)
  );

  function automatic logic [19:0] to_bcd(input int v);
    logic [19:0] r;
    int x;
    x = v;
    r = '0;
    for (int i = 0; i < 5; i++) begin
      r[4*i +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  function automatic logic [19:0] get_bcd(input int w);
    return (w == 16) ? bcd16 : {8'd0, bcd8};
  endfunction

  function automatic logic get_done(input int w);
    return (w == 16) ? done16 : done8;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input int w, input logic s, input int v);
    if (w == 16) begin start16 = s; word16 = 16'(v); end
    else begin start8 = s; word8 = 8'(v); end
  endtask

  function automatic logic nib_ok(input logic [19:0] b);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < 5; i++) if (b[4*i +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  task automatic run(input int w, input int v, input bit poke);
    logic [19:0] exp;
    exp = to_bcd(v);
    @(negedge clk);
    drive(w, 1'b1, v);
    @(negedge clk);                       // start edge passed
    drive(w, 1'b0, ~v);                   // R7: word change ignored
    chk("R4 clear on start", get_bcd(w), 0);
    chk("R5 done low after start", get_done(w), 0);
    @(negedge clk);                       // first shift edge
    chk("R3 msb first", get_bcd(w), (v >> (w - 1)) & 1);
    for (int k = 2; k < w; k++) begin
      @(negedge clk);
      if (poke && k == 3) drive(w, 1'b1, 0);   // R7: start while shifting
      if (poke && k == 4) drive(w, 1'b0, 0);
    end
    chk("R5 done low before edge N", get_done(w), 0);
    @(negedge clk);
    chk("R5 done at edge N", get_done(w), 1);
    chk(poke ? "R7 result after mid-run start" : "R1 decimal result", get_bcd(w), exp);
    chk("R2 R8 nibbles legal", nib_ok(get_bcd(w)), 1);
    repeat (2) @(negedge clk);
    chk("R6 done held", get_done(w), 1);
    chk("R6 result held", get_bcd(w), exp);
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      failures++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset bcd", bcd16, 0);
    chk("R9 reset done", done16, 0);
    chk("R9 reset done 8b", done8, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 idle after reset", {12'd0, bcd8, 7'd0, done8}, 0);
    for (int v = 0; v < 256; v++) run(8, v, (v % 17) == 0);
    run(16, 0, 1'b0);
    run(16, 1, 1'b0);
    run(16, 9, 1'b0);
    run(16, 10, 1'b0);
    run(16, 99, 1'b0);
    run(16, 9999, 1'b0);
    run(16, 10000, 1'b1);
    run(16, 32767, 1'b0);
    run(16, 32768, 1'b0);
    run(16, 65535, 1'b1);   // R8 largest value, top digit full
    for (int i = 0; i < 64; i++) run(16, (i * 1021 + 13) & 16'hffff, (i % 8) == 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule